// File: doc/BRIEF.md
# Four-Lane Byte-Sliced Asynchronous SRAM Model

A synthesizable behavioural model of a memory module made of four byte-wide banks. All banks see one shared address and one shared active-low output enable. Each bank has its own active-low chip select, its own active-low write enable, and its own 8-bit data lane. The bidirectional lane is split into an input byte, an output byte and a per-lane drive-enable bit. By selecting lanes together or apart, a host can use the module as one 32-bit bank, two 16-bit banks or four 8-bit banks.

The strobes are asynchronous at the module's pins. The model samples them on a system clock so that the write-overlap rule can be checked. A lane is writing while both its chip select and its write enable are low. The write ends when either strobe rises. The byte stored is the one that was present in the last sampled cycle in which both strobes were still low. Read data follows the address combinationally from storage.

The address width is a parameter. The nominal module uses 19 bits (512K entries per lane). The default is kept small so that elaboration stays light.

Top module: `quad_lane_sram`

## Requirements
- R1: A lane whose chip select is high is in standby. Its drive-enable bit is 0 and its output byte reads 0, whatever write enable and output enable are doing, and no write takes place on it.
- R2: With chip select low, write enable high and output enable low, the lane drives. Its drive-enable bit is 1 and its output byte equals the stored byte at the current address in the same cycle.
- R3: With chip select low and write enable low, the lane is in write mode. Its drive-enable bit is 0 and its output byte is 0, even when output enable is low.
- R4: With chip select low, write enable high and output enable high, the lane is output-disabled. Its drive-enable bit is 0 and its output byte is 0.
- R5: A write ended by write enable rising stores the input byte and address sampled in the last clock in which both strobes were low. The stored byte is readable from the clock edge that samples the release. A byte that changes together with the release is not stored.
- R6: A write ended by chip select rising stores the byte in the same way as R5.
- R7: A write happens only when both strobes are sampled low in the same cycle. Chip select and write enable pulsed low in separate cycles store nothing. If the data changes during an overlap, only the last value held before the release is stored.
- R8: Lanes are independent. A write on one lane (lane n owns input and output bits 8n+7..8n) leaves the bytes of the other lanes at that address unchanged.
- R9: While the active-low reset is low, no write is pending. Strobes that go low and are released while reset is asserted store nothing.
- R10: The address is held stable across every cycle in which a lane's strobes stay both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Active-low asynchronous reset of the strobe samplers |
| addr | input | ADDR_W | Address shared by all lanes |
| oe_n | input | 1 | Shared active-low output enable |
| cs_n | input | LANES | Per-lane active-low chip select |
| we_n | input | LANES | Per-lane active-low write enable |
| din | input | LANES*8 | Write data, lane n on bits 8n+7..8n |
| dout | output | LANES*8 | Read data, 0 on lanes that are not driving |
| dout_en | output | LANES | Per-lane drive enable (1 = lane drives its data pins) |

## Verification
On every cycle, the assertions check four things: that a commit places the held byte at the held address, that a commit never follows a cycle in which the lane was driving, that the address stays put while a lane is writing, and that the read byte stays steady while the lane keeps driving one address with no commit in between. Only the bench scenarios can show several other behaviours. These include which edge terminates a write (write enable or chip select), that data changed together with the release is dropped, that non-overlapping strobes store nothing, that lanes do not disturb each other, and that a write attempted under reset is lost. The bench shows these by comparing every cycle against a behavioural reference model and by reading the stored values back.

// File: rtl/quad_lane_sram.sv
module quad_lane_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        cs_n,
  input  logic [LANES-1:0]        we_n,
  input  logic [LANES*BYTE_W-1:0] din,
  output logic [LANES*BYTE_W-1:0] dout,
  output logic [LANES-1:0]        dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]       addr_q;
  logic [LANES*BYTE_W-1:0] din_q;
  logic [LANES-1:0]        wr_now, wr_q, commit;

  assign wr_now = ~cs_n & ~we_n;
  assign commit = wr_q & ~wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= '0;
    else        wr_q <= wr_now;
  end

  always_ff @(posedge clk) begin
    addr_q <= addr;
    din_q  <= din;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk)
      if (commit[l]) bank[addr_q] <= din_q[l*BYTE_W +: BYTE_W];

    assign dout_en[l] = ~cs_n[l] & we_n[l] & ~oe_n;
    assign dout[l*BYTE_W +: BYTE_W] = dout_en[l] ? bank[addr] : '0;

    // R5 R6
    commit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit[l] |=> bank[$past(addr_q)] == $past(din_q[l*BYTE_W +: BYTE_W]));

    // R3
    commit_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit[l] |-> $past(!dout_en[l]));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q[l] && wr_now[l]) |-> addr == addr_q);

    // R2
    read_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en[l] && $past(dout_en[l]) && addr == $past(addr) && !$past(commit[l]))
        |-> $stable(dout[l*BYTE_W +: BYTE_W]));
  end
endmodule

// File: tb/tb_quad_lane_sram.sv
module tb_quad_lane_sram;
  localparam int AW = 4;
  localparam int NL = 4;

  logic clk = 0, rst_n = 0, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] cs_n = '1, we_n = '1;
  logic [31:0] din = '0, dout;
  logic [NL-1:0] dout_en;

  int checks = 0, failures = 0;
  bit done = 0;

  int ref_mem [NL][16];
  bit ref_ok  [NL][16];
  bit was_wr  [NL];
  int last_a  [NL];
  int last_d  [NL];

  quad_lane_sram #(.ADDR_W(AW), .LANES(NL), .BYTE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .oe_n(oe_n),
    .cs_n(cs_n), .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: behavioural write-overlap rule
  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      bit now_wr;
      now_wr = !cs_n[l] && !we_n[l];
      if (!rst_n) was_wr[l] = 0;
      else begin
        if (was_wr[l] && !now_wr) begin
          ref_mem[l][last_a[l]] = last_d[l];
          ref_ok[l][last_a[l]]  = 1;
        end
        was_wr[l] = now_wr;
      end
      last_a[l] = int'(addr);
      last_d[l] = int'(din[l*8 +: 8]);
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      for (int l = 0; l < NL; l++) begin
        bit en_exp;
        string tag;
        en_exp = !cs_n[l] && we_n[l] && !oe_n;
        tag = cs_n[l] ? "R1 standby" : (!we_n[l] ? "R3 write mode" :
              (oe_n ? "R4 output disable" : "R2 read"));
        chk(dout_en[l] == en_exp, tag, int'(dout_en[l]), int'(en_exp));
        if (!en_exp)
          chk(dout[l*8 +: 8] == 8'h00, tag, int'(dout[l*8 +: 8]), 0);
        else if (ref_ok[l][addr])
          chk(int'(dout[l*8 +: 8]) == ref_mem[l][addr], tag,
              int'(dout[l*8 +: 8]), ref_mem[l][addr]);
      end
    end
  end

  task automatic drive(input logic [3:0] c, input logic [3:0] w, input logic o,
                       input int a, input logic [31:0] d);
    @(negedge clk); #1;
    cs_n = c; we_n = w; oe_n = o; addr = AW'(a); din = d;
  endtask

  task automatic idle();
    drive(4'hF, 4'hF, 1'b1, int'(addr), din);
  endtask

  task automatic wr(input logic [3:0] m, input int a, input logic [31:0] d,
                    input bit by_cs, input string tag);
    if (!by_cs) drive(~m, 4'hF, 1'b0, a, d);
    else        drive(4'hF, ~m, 1'b0, a, d);
    drive(~m, ~m, 1'b0, a, d);
    drive(~m, ~m, 1'b0, a, d);
    #2 chk((dout_en & m) == 4'h0, {tag, " R3 no drive while writing"}, int'(dout_en), 0);
    if (!by_cs) drive(~m, 4'hF, 1'b1, a, ~d);
    else        drive(4'hF, ~m, 1'b1, a, ~d);
    idle();
  endtask

  task automatic rd(input int lane, input int a, input logic [7:0] exp, input string tag);
    logic [3:0] m;
    m = 4'h1 << lane;
    drive(~m, 4'hF, 1'b0, a, din);
    #2;
    chk(dout_en[lane] == 1'b1, tag, int'(dout_en[lane]), 1);
    chk(dout[lane*8 +: 8] == exp, tag, int'(dout[lane*8 +: 8]), int'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 chk(dout_en == 4'h0 && dout == 32'h0, "R9 reset state", int'(dout), 0);
    @(negedge clk); rst_n = 1;
    idle();

    // R5: full-width write ended by write enable
    wr(4'hF, 2, 32'h44332211, 1'b0, "R5");
    rd(0, 2, 8'h11, "R5 lane0 read");
    rd(3, 2, 8'h44, "R5 lane3 read");
    rd(2, 2, 8'h33, "R2 read lane2");

    // R6 + R8: lane 1 alone, ended by chip select
    wr(4'h2, 2, 32'hFFFFA5FF, 1'b1, "R6");
    rd(1, 2, 8'hA5, "R6 lane1 read");
    rd(0, 2, 8'h11, "R8 lane0 untouched");
    rd(2, 2, 8'h33, "R8 lane2 untouched");

    // R7 data changes during overlap; R5 byte changing with release dropped
    drive(4'h7, 4'hF, 1'b1, 5, 32'h10000000);
    drive(4'h7, 4'h7, 1'b1, 5, 32'h10000000);
    drive(4'h7, 4'h7, 1'b1, 5, 32'h20000000);
    drive(4'h7, 4'hF, 1'b1, 5, 32'h30000000);
    idle();
    rd(3, 5, 8'h20, "R7 last held byte stored");

    // R7: strobes low in separate cycles store nothing
    drive(4'hE, 4'hF, 1'b1, 2, 32'h99999999);
    drive(4'hF, 4'hF, 1'b1, 2, 32'h99999999);
    drive(4'hF, 4'hE, 1'b1, 2, 32'h99999999);
    drive(4'hF, 4'hF, 1'b1, 2, 32'h99999999);
    rd(0, 2, 8'h11, "R7 no overlap no write");

    // R4: output disabled
    drive(4'h0, 4'hF, 1'b1, 2, 32'h0);
    #2 chk(dout_en == 4'h0 && dout == 32'h0, "R4 output disable", int'(dout), 0);

    // R1: standby with write enable and output enable low
    drive(4'hF, 4'h0, 1'b0, 2, 32'h55555555);
    #2 chk(dout_en == 4'h0 && dout == 32'h0, "R1 standby", int'(dout), 0);
    drive(4'hF, 4'hF, 1'b0, 2, 32'h55555555);
    rd(3, 2, 8'h44, "R1 standby stored nothing");

    // R9: write attempt under reset
    @(negedge clk); rst_n = 0; cs_n = 4'hB; we_n = 4'hB; addr = 2; din = 32'h77777777;
    @(negedge clk); cs_n = 4'hF; we_n = 4'hF;
    @(negedge clk); rst_n = 1;
    idle();
    rd(2, 2, 8'h33, "R9 no commit under reset");
    idle();
    repeat (2) @(posedge clk);
    #6;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule